// File: doc/BRIEF.md
# Dual-Clock Keyed Watchdog Timer

This watchdog takes byte-wide commands on a fast system clock and runs its timeout counter on a slow clock, after a power-of-two prescaler. Each command byte is a key. One key restarts the count. A pair of keys written back to back stops the counter. A third key makes the stop pair permanently ineffective. Any byte with bit 7 clear picks a new timeout, but only while the counter is stopped. When the counter reaches its limit, the block raises a reset request and holds it until the slow domain is reset.

Accepted commands cross from the system domain into the slow domain through a toggle handshake. The system side reports `busy` from the moment a command is accepted until the slow side acknowledges it. While `busy` is high, further writes are dropped. Software waits for `busy` to clear before it counts on the new state. Lowering the timeout while the counter is stopped can still fire a reset if the held count is already past the new limit.

Top module: `wdg_dual_clock`

## Requirements
- R1: After both resets, `busy` and `rst_req` are 0, the counter is running, and the timeout code is the parameter default (0).
- R2: Writing 0xA5 clears the count to zero and also restarts a stopped counter; refreshing more often than the timeout keeps `rst_req` low.
- R3: A running counter with timeout code n raises `rst_req` after 2^(n+BASE_EXP) prescaled ticks without a refresh (16 ticks for n=0 at the default BASE_EXP=4); `rst_req` stays high until `slow_rst`.
- R4: Writing 0xDE and then 0xAD as the very next accepted write stops the counter, so no reset request follows.
- R5: Any other accepted byte between 0xDE and 0xAD cancels the stop sequence, and the counter keeps running.
- R6: Writing 0xFF while stopped sets a lock, after which the 0xDE/0xAD pair has no effect; 0xFF written while running is ignored.
- R7: A byte with bit 7 = 0 loads bits [2:0] as the timeout code only while stopped; while running such a byte leaves the timeout unchanged.
- R8: Loading a timeout code while stopped raises `rst_req` when the held count is already at or above the new limit; a larger limit does not.
- R9: The counter advances once every 2^`div_sel` slow clock cycles.
- R10: `busy` rises on the system clock edge that accepts a command (0xA5, 0xFF, a completed stop pair, or a bit-7-clear byte) and falls after the slow side acknowledges it; the command takes effect within 3 slow clock cycles of the write.
- R11: Bytes written while `busy` is high are ignored entirely, including the first half of the stop pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte |
| busy | output | 1 | A command is crossing to the slow domain |
| slow_clk | input | 1 | Slow oscillator clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| div_sel | input | DIV_W | Prescaler select, divide by 2^div_sel |
| rst_req | output | 1 | Sticky reset request on timeout |

## Verification
Timeout behaviour is tried in several ways: periodic refreshes at seeded random spacing, a single refresh followed by silence, and seeded random timeout codes and prescaler settings. Together these separate a correct limit and tick rate from off-by-one or wrong-shift errors. Key sequences are tried in several forms: a clean stop pair, a pair broken by a stray byte, a pair sent after a lock, a lock sent while running, and a stop key sent while `busy` is high. Each form is told apart only by whether a reset request later appears. Lowering and raising the limit on a stopped counter that has already counted shows whether the comparison against the new limit fires only when it should.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int IVAL_W = 3;

    localparam logic [7:0] KEY_REFRESH = 8'hA5;
    localparam logic [7:0] KEY_STOP_A  = 8'hDE;
    localparam logic [7:0] KEY_STOP_B  = 8'hAD;
    localparam logic [7:0] KEY_LOCK    = 8'hFF;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_REFRESH,
        OP_STOP,
        OP_LOCK,
        OP_SET_IVAL
    } wdg_op_e;

    typedef struct packed {
        wdg_op_e             op;
        logic [IVAL_W-1:0]   code;
    } wdg_cmd_t;

    function automatic wdg_op_e decode_key(input logic [7:0] b, input logic armed);
        if (b == KEY_REFRESH)           return OP_REFRESH;
        else if (b == KEY_STOP_B && armed) return OP_STOP;
        else if (b == KEY_LOCK)         return OP_LOCK;
        else if (!b[7])                 return OP_SET_IVAL;
        else                            return OP_NONE;
    endfunction

endpackage

// File: rtl/wdg_sys_port.sv
module wdg_sys_port
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ack_tog_in,
    output logic       req_tog,
    output wdg_cmd_t   cmd,
    output logic       busy
);

    logic    armed;
    logic    ack_s1, ack_s2;
    wdg_op_e new_op;

    assign new_op = decode_key(wr_data, armed);
    assign busy   = req_tog ^ ack_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tog <= 1'b0;
            armed   <= 1'b0;
            ack_s1  <= 1'b0;
            ack_s2  <= 1'b0;
            cmd     <= '{op: OP_NONE, code: '0};
        end else begin
            ack_s1 <= ack_tog_in;
            ack_s2 <= ack_s1;
            if (wr_en && !busy) begin
                armed <= (wr_data == KEY_STOP_A);
                if (new_op != OP_NONE) begin
                    cmd     <= '{op: new_op, code: wr_data[IVAL_W-1:0]};
                    req_tog <= ~req_tog;
                end
            end
        end
    end

endmodule

// File: rtl/wdg_slow_sync.sv
module wdg_slow_sync
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_tog_in,
    input  wdg_cmd_t cmd_in,
    output logic     ack_tog,
    output logic     cmd_valid,
    output wdg_cmd_t cmd_out
);

    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= req_tog_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // The system side holds cmd_in steady until the acknowledge returns.
    assign cmd_valid = s2 ^ s3;
    assign cmd_out   = cmd_in;
    assign ack_tog   = s3;

endmodule

// File: rtl/wdg_counter_core.sv
module wdg_counter_core
    import wdg_pkg::*;
#(
    parameter int BASE_EXP = 4,
    parameter int DIV_W    = 2,
    parameter int RST_CODE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cmd_valid,
    input  wdg_cmd_t         cmd,
    output logic             run_en,
    output logic             locked,
    output logic             rst_req
);

    localparam int MAX_CODE = (1 << IVAL_W) - 1;
    localparam int CNT_W    = BASE_EXP + MAX_CODE + 1;
    localparam int PRE_W    = (1 << DIV_W) - 1;

    logic [IVAL_W-1:0] code;
    logic [CNT_W-1:0]  cnt, lim, new_lim;
    logic [PRE_W-1:0]  pre, mask;
    logic              tick;

    assign lim     = CNT_W'(1) << (int'(code) + BASE_EXP);
    assign new_lim = CNT_W'(1) << (int'(cmd.code) + BASE_EXP);
    assign mask    = PRE_W'((1 << div_sel) - 1);
    assign tick    = (pre & mask) == mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en  <= 1'b1;
            locked  <= 1'b0;
            code    <= IVAL_W'(RST_CODE);
            cnt     <= '0;
            pre     <= '0;
            rst_req <= 1'b0;
        end else begin
            pre <= pre + PRE_W'(1);
            if (cmd_valid) begin
                case (cmd.op)
                    OP_REFRESH: begin
                        cnt    <= '0;
                        run_en <= 1'b1;
                    end
                    OP_STOP:  if (!locked) run_en <= 1'b0;
                    OP_LOCK:  if (!run_en) locked <= 1'b1;
                    OP_SET_IVAL: if (!run_en) begin
                        code <= cmd.code;
                        if (cnt >= new_lim) rst_req <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (run_en && tick && cnt < lim) begin
                cnt <= cnt + CNT_W'(1);
                if (cnt + CNT_W'(1) >= lim) rst_req <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdg_dual_clock.sv
module wdg_dual_clock
    import wdg_pkg::*;
#(
    parameter int BASE_EXP = 4,
    parameter int DIV_W    = 2,
    parameter int RST_CODE = 0
) (
    input  logic             sys_clk,
    input  logic             sys_rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             busy,
    input  logic             slow_clk,
    input  logic             slow_rst,
    input  logic [DIV_W-1:0] div_sel,
    output logic             rst_req
);

    logic     req_tog, ack_tog, cmd_valid, run_en, locked;
    wdg_cmd_t sys_cmd, slow_cmd;

    wdg_sys_port u_sys (
        .clk(sys_clk), .rst(sys_rst), .wr_en(wr_en), .wr_data(wr_data),
        .ack_tog_in(ack_tog), .req_tog(req_tog), .cmd(sys_cmd), .busy(busy)
    );

    wdg_slow_sync u_sync (
        .clk(slow_clk), .rst(slow_rst), .req_tog_in(req_tog), .cmd_in(sys_cmd),
        .ack_tog(ack_tog), .cmd_valid(cmd_valid), .cmd_out(slow_cmd)
    );

    wdg_counter_core #(.BASE_EXP(BASE_EXP), .DIV_W(DIV_W), .RST_CODE(RST_CODE)) u_core (
        .clk(slow_clk), .rst(slow_rst), .div_sel(div_sel), .cmd_valid(cmd_valid),
        .cmd(slow_cmd), .run_en(run_en), .locked(locked), .rst_req(rst_req)
    );

endmodule

// File: rtl/wdg_dual_clock_chk.sv
module wdg_dual_clock_chk
    import wdg_pkg::*;
(
    input logic       sys_clk,
    input logic       sys_rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       slow_clk,
    input logic       slow_rst,
    input logic       rst_req,
    input logic       cmd_valid,
    input wdg_cmd_t   slow_cmd,
    input logic       run_en,
    input logic       locked
);

    AST_BUSY_ON_REFRESH: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wr_en && !busy && wr_data == KEY_REFRESH) |=> busy);                       // R10
    AST_BUSY_NEEDS_WRITE: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (!busy && !wr_en) |=> !busy);                                               // R11
    AST_CMD_SINGLE: assert property (@(posedge slow_clk) disable iff (slow_rst)
        cmd_valid |=> !cmd_valid);                                                  // R10
    AST_REQ_STICKY: assert property (@(posedge slow_clk) disable iff (slow_rst)
        rst_req |=> rst_req);                                                       // R3
    AST_REFRESH_RUNS: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (cmd_valid && slow_cmd.op == OP_REFRESH) |=> run_en);                       // R2
    AST_LOCK_BLOCKS_STOP: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (locked && cmd_valid && slow_cmd.op == OP_STOP) |=> run_en == $past(run_en)); // R6
    AST_STOPPED_QUIET: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (!run_en && !(cmd_valid && slow_cmd.op == OP_SET_IVAL)) |=> !$rose(rst_req)); // R4

endmodule

bind wdg_dual_clock wdg_dual_clock_chk u_chk (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .slow_clk(slow_clk), .slow_rst(slow_rst), .rst_req(rst_req),
    .cmd_valid(cmd_valid), .slow_cmd(slow_cmd), .run_en(run_en), .locked(locked)
);

// File: tb/wdg_dual_clock_bench.sv
module wdg_dual_clock_bench;

    logic       sys_clk = 0, slow_clk = 0;
    logic       sys_rst = 1, slow_rst = 1;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] div_sel = 0;
    logic       busy, rst_req;
    int         total = 0, fails = 0;

    always #5  sys_clk  = ~sys_clk;
    always #15 slow_clk = ~slow_clk;

    wdg_dual_clock u_wdg_dual_clock (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .slow_clk(slow_clk), .slow_rst(slow_rst),
        .div_sel(div_sel), .rst_req(rst_req)
    );

    function automatic int lo_win(input int code, input int dv);
        return (1 << (code + 4)) * dv - 2 * dv - 2;
    endfunction
    function automatic int hi_win(input int code, input int dv);
        return (1 << (code + 4)) * dv + 2 * dv + 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        sys_rst = 1; slow_rst = 1;
        repeat (4) @(negedge slow_clk);
        @(negedge sys_clk); sys_rst = 0; slow_rst = 0;
        repeat (2) @(negedge slow_clk);
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge sys_clk); wr_en = 1; wr_data = b;
        @(negedge sys_clk); wr_en = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge sys_clk);
    endtask

    task automatic wr_idle(input logic [7:0] b);
        wr(b); wait_idle();
    endtask

    task automatic measure(input int maxc, output int n);
        n = 0;
        while (!rst_req && n < maxc) begin
            @(negedge slow_clk); n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n, lat, gap, code, dv;
        bit seen;
        n = $urandom(32'd2718);

        // R1 reset state
        do_reset();
        chk(busy == 0, "R1 busy", busy, 0);
        chk(rst_req == 0, "R1 rst_req", rst_req, 0);

        // R10 busy rises after accepted write and clears within bound
        wr(8'hA5);
        chk(busy == 1, "R10 busy after write", busy, 1);
        lat = 0;
        while (busy && lat < 100) begin @(negedge sys_clk); lat++; end
        chk(lat >= 3 && lat <= 16, "R10 busy duration", lat, 12);

        // R1/R3 default timeout 16 ticks
        measure(200, n);
        chk(n >= lo_win(0, 1) && n <= hi_win(0, 1), "R3 expiry time", n, 16);
        repeat (5) @(negedge slow_clk);
        chk(rst_req == 1, "R3 sticky", rst_req, 1);

        // R2 random refresh spacing keeps it alive
        do_reset();
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            wr_idle(8'hA5);
            gap = $urandom_range(1, 7);
            repeat (gap) begin @(negedge slow_clk); if (rst_req) seen = 1; end
        end
        chk(!seen, "R2 keep alive", seen, 0);
        wait_idle();
        measure(200, n);
        chk(n >= lo_win(0, 1) && n <= hi_win(0, 1), "R2 expiry after last refresh", n, 16);

        // R4 stop pair
        do_reset();
        wr(8'hDE); wr_idle(8'hAD);
        measure(200, n);
        chk(n == 200, "R4 stopped", n, 200);

        // R5 aborted pair
        do_reset();
        wr(8'hDE); wr_idle(8'h33); wr_idle(8'hAD); wr_idle(8'hA5);
        measure(200, n);
        chk(n >= lo_win(0, 1) && n <= hi_win(0, 1), "R5 abort keeps running", n, 16);

        // R6 lock while stopped
        do_reset();
        wr(8'hDE); wr_idle(8'hAD); wr_idle(8'hFF); wr_idle(8'hA5);
        wr(8'hDE); wr_idle(8'hAD);
        measure(200, n);
        chk(n >= lo_win(0, 1) && n <= hi_win(0, 1), "R6 lock blocks stop", n, 16);
        // R6 lock while running ignored
        do_reset();
        wr_idle(8'hFF); wr(8'hDE); wr_idle(8'hAD);
        measure(200, n);
        chk(n == 200, "R6 lock while running ignored", n, 200);

        // R7 interval ignored while running
        do_reset();
        wr_idle(8'h02); wr_idle(8'hA5);
        measure(300, n);
        chk(n >= lo_win(0, 1) && n <= hi_win(0, 1), "R7 ignored while running", n, 16);

        // R7/R9 random codes and dividers while stopped
        for (int i = 0; i < 4; i++) begin
            code = $urandom_range(0, 2);
            dv = $urandom_range(0, 2);
            div_sel = 2'(dv);
            do_reset();
            wr(8'hDE); wr_idle(8'hAD);
            wr_idle(8'(code)); wr_idle(8'hA5);
            measure(2000, n);
            chk(n >= lo_win(code, 1 << dv) && n <= hi_win(code, 1 << dv),
                "R7 R9 code/divider timeout", n, (1 << (code + 4)) * (1 << dv));
        end

        // R9 directed divide by 4
        div_sel = 2;
        do_reset();
        wr_idle(8'hA5);
        measure(500, n);
        chk(n >= lo_win(0, 4) && n <= hi_win(0, 4), "R9 divide by 4", n, 64);
        div_sel = 0;

        // R8 shrinking limit while stopped
        do_reset();
        wr(8'hDE); wr_idle(8'hAD); wr_idle(8'h02); wr_idle(8'hA5);
        repeat (40) @(negedge slow_clk);
        chk(rst_req == 0, "R8 before stop", rst_req, 0);
        wr(8'hDE); wr_idle(8'hAD);
        wr_idle(8'h03);
        repeat (4) @(negedge slow_clk);
        chk(rst_req == 0, "R8 larger limit no reset", rst_req, 0);
        wr_idle(8'h00);
        repeat (4) @(negedge slow_clk);
        chk(rst_req == 1, "R8 smaller limit resets", rst_req, 1);

        // R11 write while busy dropped
        do_reset();
        wr(8'hA5); wr(8'hDE);
        wait_idle();
        wr_idle(8'hAD);
        measure(200, n);
        chk(n >= lo_win(0, 1) && n <= hi_win(0, 1), "R11 busy write ignored", n, 16);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule